// File: doc/BRIEF.md
# Parallel FPGA configuration loader

The loader writes a byte-wide configuration stream into a target FPGA through that device's slave parallel configuration port. It makes the configuration clock itself and raises that clock only after a new byte is already on the data bus. Clock and data therefore cannot skew against each other the way they can when a free-running clock is gated by a chip select. Bytes arrive from upstream over a valid/ready handshake. A flag on the final byte marks the end of the stream.

Before loading, the requester chooses between two kinds of load. A full load first clears the target's configuration memory with a timed low pulse on the program pin, then waits for the target to report that it is ready for data. A scrub load rewrites configuration over the running design and skips both of those steps. Once the last byte is sent, the loader keeps clocking filler bytes until the target raises DONE. It then gives a fixed number of extra clocks so the target can finish its startup sequence, and reports success. It reports an error if the target pulls INIT_B low while the port is selected, or if DONE does not rise within a programmable number of filler clocks.

Top module: `cfg_loader`

## Requirements
- R1: `cfg_d` changes only while `cclk` is low. A byte is on the bus for at least HALF system cycles before the rising `cclk` edge that presents it.
- R2: The `cclk` high phase lasts exactly HALF system cycles and every low phase lasts at least HALF cycles, where HALF = ceil(CLK_HZ / (2 * CCLK_MAX_HZ)). With the defaults, HALF is 2 cycles, giving a `cclk` period of 20 ns or more.
- R3: On `start` with `scrub` = 0, `prog_b` goes low for exactly floor(PROG_LOW_NS * CLK_HZ / 1e9) + 1 cycles, which is 61 cycles with the defaults. `cs_b` stays high throughout.
- R4: After `prog_b` returns high in a full load, `cs_b` stays high until `init_b` is high.
- R5: `cs_b` and `rdwr_b` go low together at least HALF cycles before the first rising `cclk` edge. They stay low at every rising `cclk` edge of a load, and are high whenever the loader is idle.
- R6: If `busy` is high at a rising `cclk` edge, the same byte is presented again on the next pulse. `in_ready` stays low until that byte has been clocked with `busy` low.
- R7: After `done_in` is seen high between pulses, exactly STARTUP_CCLKS (12) further rising `cclk` edges occur. The loader then sets `cfg_ok` and returns `cs_b` high.
- R8: On `start` with `scrub` = 1, `prog_b` is never pulsed and no wait for `init_b` occurs.
- R9: If `init_b` is low while `cs_b` is low, then in the next cycle `err_init` is 1, `cs_b` and `rdwr_b` are high and `cclk` is low.
- R10: After the last byte, filler pulses carry 8'hFF on `cfg_d` until `done_in` is seen. If `timeout_limit` filler pulses pass without `done_in`, `err_timeout` is set and no startup pulses follow. A limit of 0 times out at once.
- R11: `in_ready` is high only while bytes are being accepted and no pulse or repeat is pending. It is never high while `cclk` is high. Each accepted byte is clocked exactly once without `busy`, in acceptance order.
- R12: Reset gives `prog_b`=1, `cs_b`=1, `rdwr_b`=1, `cclk`=0, `in_ready`=0 and all three status flags 0. `start` clears the status flags. `cfg_ok` is never set together with an error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (one-cycle pulse, taken while idle) |
| scrub | input | 1 | Sampled with start: 1 = scrub load, 0 = full load with erase |
| timeout_limit | input | TMO_W | Filler pulses allowed before DONE must rise |
| in_data | input | DW | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_last | input | 1 | Marks the final stream byte |
| in_ready | output | 1 | Loader can take a byte this cycle |
| prog_b | output | 1 | Memory clear request to target, active low |
| cs_b | output | 1 | Port select to target, active low |
| rdwr_b | output | 1 | Direction to target, low = write |
| cclk | output | 1 | Configuration clock to target |
| cfg_d | output | DW | Data bus to target |
| init_b | input | 1 | Target ready / error indication, low = not ready or error |
| busy | input | 1 | Target cannot take the current byte |
| done_in | input | 1 | Target configuration complete |
| cfg_ok | output | 1 | Last load ended with DONE and startup clocks |
| err_init | output | 1 | Last load aborted by INIT_B low |
| err_timeout | output | 1 | Last load saw no DONE within the limit |

## Verification
The bench builds the loader with its default parameters: a 200 MHz system clock, a 50 MHz clock ceiling, a 300 ns erase pulse and 12 startup clocks. These give a two-cycle clock half-period and a 61-cycle erase pulse. Both are short enough that full loads, scrub loads, stalls and timeouts all fit in a brief run, while the half-period is still long enough that low and high phase lengths can be told apart. Because `timeout_limit` is an input, both the zero boundary and a small nonzero limit can be driven without rebuilding.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_INIT,
    ST_SETUP,
    ST_DATA,
    ST_WAIT_DONE,
    ST_STARTUP
  } ld_state_t;

  // System cycles per configuration clock phase, rounded up so the
  // generated clock never exceeds max_hz.
  function automatic int half_cycles(int clk_hz, int max_hz);
    longint num;
    longint den;
    int     r;
    num = longint'(clk_hz);
    den = 2 * longint'(max_hz);
    r   = int'((num + den - 1) / den);
    if (r < 1) r = 1;
    return r;
  endfunction

  // Cycles for an erase pulse strictly longer than low_ns.
  function automatic int prog_cycles(int clk_hz, int low_ns);
    longint prod;
    prod = longint'(low_ns) * longint'(clk_hz);
    return int'(prod / 64'd1_000_000_000) + 1;
  endfunction

  function automatic int count_width(int n);
    int w;
    w = $clog2(n + 1);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/cfg_loader_timer.sv
module cfg_loader_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/cfg_loader_cclk.sv
module cfg_loader_cclk #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic abort,
  output logic cclk,
  output logic active,
  output logic rise,
  output logic fin
);

  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] RELOAD = HW'(HALF - 1);

  logic [HW-1:0] cnt;
  logic          hi;
  logic          act;

  assign cclk   = hi;
  assign active = act;
  assign rise   = act && !hi && (cnt == '0);
  assign fin    = act && hi && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      hi  <= 1'b0;
      cnt <= '0;
    end else if (abort) begin
      act <= 1'b0;
      hi  <= 1'b0;
      cnt <= '0;
    end else if (!act) begin
      if (go) begin
        act <= 1'b1;
        hi  <= 1'b0;
        cnt <= RELOAD;
      end
    end else if (cnt == '0) begin
      if (!hi) begin
        hi  <= 1'b1;
        cnt <= RELOAD;
      end else begin
        act <= 1'b0;
        hi  <= 1'b0;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int DW            = 8,
  parameter int TMO_W         = 16,
  parameter int STARTUP_CCLKS = 12,
  parameter int PROG_CYC      = 61,
  parameter int HALF          = 2,
  parameter int TW            = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scrub,
  input  logic [TMO_W-1:0] timeout_limit,
  input  logic [DW-1:0]    in_data,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             init_b,
  input  logic             busy,
  input  logic             done_in,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  input  logic             cg_active,
  input  logic             cg_rise,
  input  logic             cg_fin,
  output logic             cg_go,
  output logic             cg_abort,
  output logic             prog_b,
  output logic             cs_b,
  output logic             rdwr_b,
  output logic [DW-1:0]    cfg_d,
  output logic             byte_take,
  output logic             cfg_ok,
  output logic             err_init,
  output logic             err_timeout
);

  localparam int SW = count_width(STARTUP_CCLKS);
  localparam logic [SW-1:0] SU_LAST = SW'(STARTUP_CCLKS);

  ld_state_t        state;
  logic [DW-1:0]    data_q;
  logic             last_q;
  logic             busy_hit;
  logic             retry;
  logic [TMO_W-1:0] pcount;
  logic [SW-1:0]    scnt;

  logic port_on;
  logic init_fault;
  logic wait_pulse;
  logic su_pulse;
  logic retry_pulse;

  assign port_on = (state == ST_SETUP) || (state == ST_DATA) ||
                   (state == ST_WAIT_DONE) || (state == ST_STARTUP);

  assign cs_b   = !port_on;
  assign rdwr_b = !port_on;
  assign prog_b = (state != ST_PROG);
  assign cfg_d  = data_q;

  assign init_fault  = port_on && !init_b;
  assign in_ready    = (state == ST_DATA) && !cg_active && !retry && init_b;
  assign byte_take   = in_valid && in_ready;
  assign retry_pulse = (state == ST_DATA) && retry && !cg_active;
  assign wait_pulse  = (state == ST_WAIT_DONE) && !cg_active && !done_in &&
                       (pcount != timeout_limit);
  assign su_pulse    = (state == ST_STARTUP) && !cg_active && (scnt != SU_LAST);

  assign cg_go    = !init_fault && (byte_take || retry_pulse || wait_pulse || su_pulse);
  assign cg_abort = init_fault;

  assign tmr_load = ((state == ST_IDLE) && start) ||
                    ((state == ST_WAIT_INIT) && init_b);
  assign tmr_val  = ((state == ST_IDLE) && !scrub) ? TW'(PROG_CYC - 1) : TW'(HALF - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      data_q      <= '0;
      last_q      <= 1'b0;
      busy_hit    <= 1'b0;
      retry       <= 1'b0;
      pcount      <= '0;
      scnt        <= '0;
      cfg_ok      <= 1'b0;
      err_init    <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cfg_ok      <= 1'b0;
            err_init    <= 1'b0;
            err_timeout <= 1'b0;
            retry       <= 1'b0;
            busy_hit    <= 1'b0;
            last_q      <= 1'b0;
            state       <= scrub ? ST_SETUP : ST_PROG;
          end
        end
        ST_PROG: begin
          if (tmr_expired) state <= ST_WAIT_INIT;
        end
        ST_WAIT_INIT: begin
          if (init_b) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (init_fault) begin
            err_init <= 1'b1;
            state    <= ST_IDLE;
          end else if (tmr_expired) begin
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (init_fault) begin
            err_init <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            if (byte_take) begin
              data_q <= in_data;
              last_q <= in_last;
            end
            if (cg_rise) busy_hit <= busy;
            if (retry_pulse) retry <= 1'b0;
            if (cg_fin) begin
              if (busy_hit) begin
                retry <= 1'b1;
              end else if (last_q) begin
                data_q <= '1;
                pcount <= '0;
                state  <= ST_WAIT_DONE;
              end
            end
          end
        end
        ST_WAIT_DONE: begin
          if (init_fault) begin
            err_init <= 1'b1;
            state    <= ST_IDLE;
          end else if (!cg_active) begin
            if (done_in) begin
              scnt  <= '0;
              state <= ST_STARTUP;
            end else if (pcount == timeout_limit) begin
              err_timeout <= 1'b1;
              state       <= ST_IDLE;
            end else begin
              pcount <= pcount + 1'b1;
            end
          end
        end
        ST_STARTUP: begin
          if (init_fault) begin
            err_init <= 1'b1;
            state    <= ST_IDLE;
          end else if (!cg_active) begin
            if (scnt == SU_LAST) begin
              cfg_ok <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int CLK_HZ        = 200_000_000,
  parameter int CCLK_MAX_HZ   = 50_000_000,
  parameter int PROG_LOW_NS   = 300,
  parameter int STARTUP_CCLKS = 12,
  parameter int TMO_W         = 16,
  parameter int DW            = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scrub,
  input  logic [TMO_W-1:0] timeout_limit,
  input  logic [DW-1:0]    in_data,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  output logic             prog_b,
  output logic             cs_b,
  output logic             rdwr_b,
  output logic             cclk,
  output logic [DW-1:0]    cfg_d,
  input  logic             init_b,
  input  logic             busy,
  input  logic             done_in,
  output logic             cfg_ok,
  output logic             err_init,
  output logic             err_timeout
);

  localparam int HALF     = half_cycles(CLK_HZ, CCLK_MAX_HZ);
  localparam int PROG_CYC = prog_cycles(CLK_HZ, PROG_LOW_NS);
  localparam int TMAX     = (PROG_CYC > HALF) ? PROG_CYC : HALF;
  localparam int TW       = count_width(TMAX);

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;
  logic          cg_go;
  logic          cg_abort;
  logic          cg_active;
  logic          cclk_rise;
  logic          cclk_fin;
  logic          byte_take;

  cfg_loader_timer #(.W(TW)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  cfg_loader_cclk #(.HALF(HALF)) cclk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (cg_go),
    .abort  (cg_abort),
    .cclk   (cclk),
    .active (cg_active),
    .rise   (cclk_rise),
    .fin    (cclk_fin)
  );

  cfg_loader_ctrl #(
    .DW            (DW),
    .TMO_W         (TMO_W),
    .STARTUP_CCLKS (STARTUP_CCLKS),
    .PROG_CYC      (PROG_CYC),
    .HALF          (HALF),
    .TW            (TW)
  ) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .scrub         (scrub),
    .timeout_limit (timeout_limit),
    .in_data       (in_data),
    .in_valid      (in_valid),
    .in_last       (in_last),
    .in_ready      (in_ready),
    .init_b        (init_b),
    .busy          (busy),
    .done_in       (done_in),
    .tmr_expired   (tmr_expired),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .cg_active     (cg_active),
    .cg_rise       (cclk_rise),
    .cg_fin        (cclk_fin),
    .cg_go         (cg_go),
    .cg_abort      (cg_abort),
    .prog_b        (prog_b),
    .cs_b          (cs_b),
    .rdwr_b        (rdwr_b),
    .cfg_d         (cfg_d),
    .byte_take     (byte_take),
    .cfg_ok        (cfg_ok),
    .err_init      (err_init),
    .err_timeout   (err_timeout)
  );

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cclk,
  input logic          cclk_rise,
  input logic          byte_take,
  input logic          cs_b,
  input logic          rdwr_b,
  input logic          prog_b,
  input logic [DW-1:0] cfg_d,
  input logic          in_ready,
  input logic          init_b,
  input logic          cfg_ok,
  input logic          err_init,
  input logic          err_timeout
);

  // R1
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(cfg_d));

  // R1
  data_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_rise |=> (cclk && $stable(cfg_d)));

  // R5
  port_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> (!cs_b && !rdwr_b));

  // R3
  erase_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_b |-> cs_b);

  // R11
  ready_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cclk);

  // R11
  take_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |-> !cclk_rise);

  // R9
  init_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_b && !init_b) |=> (cs_b && rdwr_b && !cclk && err_init));

  // R12
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ok && (err_init || err_timeout)));

endmodule

bind cfg_loader cfg_loader_chk #(.DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cclk        (cclk),
  .cclk_rise   (cclk_rise),
  .byte_take   (byte_take),
  .cs_b        (cs_b),
  .rdwr_b      (rdwr_b),
  .prog_b      (prog_b),
  .cfg_d       (cfg_d),
  .in_ready    (in_ready),
  .init_b      (init_b),
  .cfg_ok      (cfg_ok),
  .err_init    (err_init),
  .err_timeout (err_timeout)
);

// File: tb/cfg_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_loader_tb_top;

  localparam int CLK_HZ   = 200_000_000;
  localparam int MAX_HZ   = 50_000_000;
  localparam int LOW_NS   = 300;
  localparam int SU_N     = 12;
  localparam int EXP_HALF = (CLK_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ);
  localparam int EXP_PROG = (LOW_NS * (CLK_HZ / 1_000_000)) / 1000 + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        scrub = 1'b0;
  logic [15:0] timeout_limit = 16'd100;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        prog_b, cs_b, rdwr_b, cclk;
  logic [7:0]  cfg_d;
  logic        init_b;
  logic        busy = 1'b0;
  logic        done_in;
  logic        cfg_ok, err_init, err_timeout;

  always #2.5 clk = ~clk;

  cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .scrub(scrub),
    .timeout_limit(timeout_limit), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .prog_b(prog_b), .cs_b(cs_b),
    .rdwr_b(rdwr_b), .cclk(cclk), .cfg_d(cfg_d), .init_b(init_b),
    .busy(busy), .done_in(done_in), .cfg_ok(cfg_ok), .err_init(err_init),
    .err_timeout(err_timeout)
  );

  // Target model: INIT_B low during erase and 10 cycles after it.
  logic init_model_low = 1'b0;
  logic init_force = 1'b0;
  int   init_cnt = 0;
  assign init_b = !(init_model_low || init_force);

  always @(negedge clk) begin
    if (!prog_b) begin
      init_model_low <= 1'b1;
      init_cnt <= 0;
    end else if (init_model_low) begin
      init_cnt <= init_cnt + 1;
      if (init_cnt == 9) init_model_low <= 1'b0;
    end
  end

  // Scoreboard
  logic [7:0] exp_q[$];
  int mon_total = 0, mon_fail = 0;
  int rx_cnt = 0, filler_cnt = 0, post_done_cnt = 0, stall_rises = 0;
  int filler_base = 0;
  int done_after = 0;
  bit done_en = 1'b0;

  assign done_in = done_en && ((filler_cnt - filler_base) >= done_after);

  always @(posedge cclk) begin
    if (!cs_b) begin
      if (busy) begin
        stall_rises++;
      end else if (exp_q.size() > 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        mon_total++;
        rx_cnt++;
        if (cfg_d !== e) begin
          mon_fail++;
          $display("FAIL R11 byte order: actual %02h expected %02h", cfg_d, e);
        end
      end else begin
        mon_total++;
        if (cfg_d !== 8'hFF) begin
          mon_fail++;
          $display("FAIL R10 filler byte: actual %02h expected ff", cfg_d);
        end
        if (done_in) post_done_cnt++;
        filler_cnt++;
      end
    end
  end

  // Port observers
  int prog_low_cnt = 0, init_viol = 0, ready_hi_cclk = 0;
  int hi_run = 0, lo_run = 0, min_hi = 1000, max_hi = 0, min_lo = 1000;
  bit lo_valid = 1'b0, prev_cclk = 1'b0, first_seen = 1'b0;
  int cs_low_run = 0, first_gap = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prog_b) prog_low_cnt++;
      if (!cs_b && !init_b && !init_force) init_viol++;
      if (in_ready && cclk) ready_hi_cclk++;
      if (cs_b) begin
        cs_low_run = 0;
        first_seen = 1'b0;
      end else begin
        cs_low_run++;
        if (cclk && !first_seen) begin
          first_gap = cs_low_run;
          first_seen = 1'b1;
        end
      end
      if (cclk) begin
        if (!prev_cclk && lo_valid && lo_run < min_lo) min_lo = lo_run;
        hi_run++;
        lo_run = 0;
      end else begin
        if (prev_cclk && !cs_b) begin
          if (hi_run < min_hi) min_hi = hi_run;
          if (hi_run > max_hi) max_hi = hi_run;
          lo_valid = 1'b1;
        end
        hi_run = 0;
        lo_run++;
      end
      if (cs_b) begin
        lo_valid = 1'b0;
        lo_run = 0;
      end
      prev_cclk = cclk;
    end
  end

  int total = 0, fails = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_bytes(int n, logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      int w;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seed + 8'(i * 37);
      in_last  = (i == n - 1);
      w = 0;
      while (!in_ready && w < 400) begin
        @(negedge clk);
        w++;
      end
      if (w >= 400) begin
        in_valid = 1'b0;
        break;
      end
      exp_q.push_back(in_data);
      @(negedge clk);
      in_valid = 1'b0;
      in_last = 1'b0;
    end
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic kick(bit sc, int lim, bit den, int dafter);
    filler_base = filler_cnt;
    done_after  = dafter;
    done_en     = den;
    timeout_limit = 16'(lim);
    @(negedge clk);
    scrub = sc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int k;
    k = 0;
    while (!(cfg_ok || err_init || err_timeout) && k < 20000) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      $display("FAIL watchdog all requirements: actual %0d cycles expected finish", wd);
      $display("%0d/%0d checks passed", total + mon_total - fails - mon_fail,
               total + mon_total + 1);
      $finish;
    end
  end

  initial begin
    int pb, fb, pd, rb, sb, bad;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(prog_b == 1'b1, "R12 prog_b reset", int'(prog_b), 1);
    chk(cs_b == 1'b1 && rdwr_b == 1'b1, "R12 cs_b/rdwr_b reset", int'(cs_b), 1);
    chk(cclk == 1'b0, "R12 cclk reset", int'(cclk), 0);
    chk(in_ready == 1'b0, "R12 in_ready reset", int'(in_ready), 0);
    chk(!cfg_ok && !err_init && !err_timeout, "R12 flags reset",
        int'({cfg_ok, err_init, err_timeout}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Full load
    pb = prog_low_cnt; fb = filler_cnt; pd = post_done_cnt; rb = rx_cnt;
    kick(1'b0, 100, 1'b1, 3);
    send_bytes(6, 8'h11);
    wait_end();
    chk(prog_low_cnt - pb == EXP_PROG, "R3 erase pulse length", prog_low_cnt - pb, EXP_PROG);
    chk(init_viol == 0, "R4 select before INIT_B", init_viol, 0);
    chk(first_gap >= EXP_HALF + 1, "R5 select lead before first edge", first_gap, EXP_HALF + 1);
    chk(rx_cnt - rb == 6, "R11 bytes clocked", rx_cnt - rb, 6);
    chk(filler_cnt - fb == 3 + SU_N, "R10 filler plus startup edges", filler_cnt - fb, 3 + SU_N);
    chk(post_done_cnt - pd == SU_N, "R7 startup edges after DONE", post_done_cnt - pd, SU_N);
    chk(cfg_ok && !err_init && !err_timeout, "R7 cfg_ok after full load",
        int'({cfg_ok, err_init, err_timeout}), 4);
    chk(cs_b && rdwr_b, "R5 port released when idle", int'(cs_b), 1);

    // Scrub load, DONE already high
    pb = prog_low_cnt; fb = filler_cnt; pd = post_done_cnt;
    kick(1'b1, 100, 1'b1, 0);
    send_bytes(5, 8'h40);
    wait_end();
    chk(prog_low_cnt - pb == 0, "R8 no erase in scrub", prog_low_cnt - pb, 0);
    chk(post_done_cnt - pd == SU_N, "R7 startup edges in scrub", post_done_cnt - pd, SU_N);
    chk(filler_cnt - fb == SU_N, "R10 no filler when DONE high", filler_cnt - fb, SU_N);
    chk(cfg_ok, "R8 scrub completes", int'(cfg_ok), 1);

    // BUSY stall
    sb = stall_rises; rb = rx_cnt; bad = 0;
    busy = 1'b1;
    kick(1'b1, 100, 1'b1, 2);
    fork
      send_bytes(3, 8'hA0);
      begin
        while (stall_rises < sb + 3) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
          @(negedge clk);
          if (in_ready) bad++;
        end
        busy = 1'b0;
      end
    join
    wait_end();
    chk(stall_rises - sb >= 3, "R6 stalled edges seen", stall_rises - sb, 3);
    chk(bad == 0, "R6 in_ready low while stalled", bad, 0);
    chk(rx_cnt - rb == 3, "R6 stalled byte delivered once", rx_cnt - rb, 3);
    chk(cfg_ok, "R6 load completes after stall", int'(cfg_ok), 1);

    // INIT_B error mid-transfer
    rb = rx_cnt;
    kick(1'b0, 100, 1'b1, 3);
    chk(!cfg_ok, "R12 flags cleared by start", int'(cfg_ok), 0);
    fork
      send_bytes(6, 8'h05);
      begin
        while (rx_cnt < rb + 2) @(negedge clk);
        init_force = 1'b1;
        @(negedge clk);
        chk(err_init == 1'b1, "R9 err_init set", int'(err_init), 1);
        chk(cs_b && rdwr_b, "R9 port released", int'(cs_b), 1);
        chk(cclk == 1'b0, "R9 clock parked low", int'(cclk), 0);
      end
    join
    exp_q.delete();
    init_force = 1'b0;
    repeat (5) @(negedge clk);
    chk(cfg_ok == 1'b0, "R9 no success after abort", int'(cfg_ok), 0);

    // DONE timeout
    fb = filler_cnt;
    kick(1'b1, 5, 1'b0, 0);
    chk(!err_init, "R12 err_init cleared by start", int'(err_init), 0);
    send_bytes(2, 8'h77);
    wait_end();
    chk(err_timeout && !cfg_ok, "R10 timeout flagged", int'(err_timeout), 1);
    chk(filler_cnt - fb == 5, "R10 filler edges before timeout", filler_cnt - fb, 5);

    // Zero limit boundary
    fb = filler_cnt;
    kick(1'b1, 0, 1'b0, 0);
    send_bytes(1, 8'h3C);
    wait_end();
    chk(err_timeout, "R10 zero limit timeout", int'(err_timeout), 1);
    chk(filler_cnt - fb == 0, "R10 zero limit no filler", filler_cnt - fb, 0);

    // Clock shape and handshake over all loads
    chk(min_hi == EXP_HALF && max_hi == EXP_HALF, "R2 high phase length", min_hi, EXP_HALF);
    chk(min_lo >= EXP_HALF, "R2 low phase length", min_lo, EXP_HALF);
    chk(ready_hi_cclk == 0, "R11 ready while clock high", ready_hi_cclk, 0);
    chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", total + mon_total - fails - mon_fail, total + mon_total);
    $finish;
  end

endmodule